// File: doc/BRIEF.md
# Shaped ON-OFF Cell Source

This block is a synthesizable stimulus engine that offers one cell opportunity per clock slot to a reassembly unit under test. It alternates between an active phase, in which it emits the cells of exactly one packet, and a silent phase of idle slots. Both the packet length in cells and the silent length in slots are geometric. Each is drawn from an 8-bit per-slot probability that is compared with a pseudo-random lane.

A third probability, the source rate, spaces the cells of a packet. In each slot of the active phase a cell goes out only when the rate draw succeeds. This stretches the packet in time but never changes its cell count. Every emitted cell carries a running sequence number, the number of the packet it belongs to, a virtual-circuit label and an end-of-packet flag. A downstream checker can use these to confirm ordering and packet integrity. Loading a seed restarts the generator from a known point, so a run can be repeated exactly.

Top module: `onoff_cell_src`

## Requirements
- R1: `cell_eop` is high only together with `cell_vld`. Every cell carries in `cell_pkt` the number of its packet. That number stays the same from the first cell of a packet through its end-of-packet cell, and the next packet's cells carry that number plus one.
- R2: A silent-phase slot never carries a cell. A slot decision (including the one made on an end-of-packet cell) starts a new packet in the next slot when the gap draw is at most `gap_prob`. Otherwise the generator stays silent, so `gap_prob`=255 gives zero idle slots between packets.
- R3: After each emitted cell, the packet ends, and that cell carries `cell_eop`, when the length draw is at most `len_prob`. A packet therefore has at least one cell, and `len_prob`=255 makes every cell an end-of-packet cell.
- R4: A slot of the active phase carries a cell when the rate draw is at most `rate`. With `rate`=255 the cells of a packet leave in consecutive slots.
- R5: The length lane advances only on slots that carry a cell. For the same seed and `len_prob`, the sequence of packet lengths is therefore the same for every `rate`.
- R6: `cell_seq` is 0 on the first cell after reset or seed load and rises by one on every later cell.
- R7: Holding `seed_load` high for a slot does four things: it reloads the rate, length and gap lanes (in that order) with `seed_val` XOR 0x0000, 0x5A5A and 0xC3C3, using 0x0001 in place of an all-zero result; it enters the active phase; it clears both counters; and it makes the next output slot idle with all fields zero. Each lane is a 16-bit right-shifting Galois LFSR with tap mask 0xB400, and its draw is its low 8 bits.
- R8: Reset makes every output zero and seeds the lanes as in R7, with the default seed 0xACE1.
- R9: Each cell carries the `vc_label` value present in the slot that produced it. Idle slots hold the last cell's sequence, packet and label fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Reload lanes from `seed_val` and restart |
| seed_val | input | 16 | Seed for repeatable runs |
| len_prob | input | 8 | Per-cell chance of ending the packet |
| gap_prob | input | 8 | Per-slot chance of ending the silent phase |
| rate | input | 8 | Per-slot chance of a cell in the active phase |
| vc_label | input | 12 | Label stamped on emitted cells |
| cell_vld | output | 1 | Slot carries a cell |
| cell_eop | output | 1 | Cell is the last of its packet |
| cell_seq | output | 16 | Running cell sequence number |
| cell_pkt | output | 16 | Packet number of the cell |
| cell_vc | output | 12 | Label of the cell |

## Verification
An end-of-packet decision and an end-of-silence decision can land in one slot. The packet then closes and the next packet starts in the very next slot, with no idle slot in between. The bench provokes this with `gap_prob` at 255 and also at mid values, where some end-of-packet cells are followed at once by the next packet's first cell. It judges the result slot by slot against a behavioural model that tracks phase, lanes and counters. A seed load arriving in the middle of a packet is the second overlap. It is judged by the first post-load cell showing sequence 0 and packet 0.

// File: rtl/onoff_src_pkg.sv
package onoff_src_pkg;
   typedef enum logic {PH_SILENT = 1'b0, PH_ACTIVE = 1'b1} phase_t;

   localparam int N_LANE    = 3;
   localparam int LANE_RATE = 0;
   localparam int LANE_LEN  = 1;
   localparam int LANE_GAP  = 2;

   // Per-lane seed scrambler so the three draws are decorrelated.
   function automatic logic [63:0] lane_salt(input int idx);
      case (idx)
         LANE_LEN: return 64'h5A5A;
         LANE_GAP: return 64'hC3C3;
         default:  return 64'h0000;
      endcase
   endfunction
endpackage

// File: rtl/onoff_lfsr.sv
module onoff_lfsr #(
   parameter int          W        = 16,
   parameter int          DRAW_W   = 8,
   parameter logic [W-1:0] TAPS    = 16'hB400,
   parameter logic [W-1:0] DEF_SEED = 16'hACE1,
   parameter logic [63:0] SALT     = 64'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [W-1:0]      seed_i,
   input  logic              step_i,
   output logic [DRAW_W-1:0] draw_o
);
   localparam logic [W-1:0] SALT_W = SALT[W-1:0];

   if (W > 64) begin : g_bad_w
      $error("onoff_lfsr: W must not exceed 64");
   end
   if (DRAW_W > W) begin : g_bad_draw
      $error("onoff_lfsr: DRAW_W must not exceed W");
   end

   function automatic logic [W-1:0] non_zero(input logic [W-1:0] v);
      return (v == '0) ? {{(W-1){1'b0}}, 1'b1} : v;
   endfunction

   logic [W-1:0] st_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       st_q <= non_zero(DEF_SEED ^ SALT_W);
      else if (load_i)  st_q <= non_zero(seed_i ^ SALT_W);
      else if (step_i)  st_q <= (st_q >> 1) ^ (st_q[0] ? TAPS : '0);
   end

   assign draw_o = st_q[DRAW_W-1:0];
endmodule

// File: rtl/onoff_slot_ctrl.sv
module onoff_slot_ctrl
   import onoff_src_pkg::*;
#(
   parameter int PROB_W = 8
) (
   input  phase_t            phase_i,
   input  logic [PROB_W-1:0] draw_rate_i,
   input  logic [PROB_W-1:0] draw_len_i,
   input  logic [PROB_W-1:0] draw_gap_i,
   input  logic [PROB_W-1:0] rate_i,
   input  logic [PROB_W-1:0] len_prob_i,
   input  logic [PROB_W-1:0] gap_prob_i,
   output logic              cell_o,
   output logic              eop_o,
   output phase_t            phase_nxt_o
);
   logic gap_done;

   always_comb begin
      gap_done    = (draw_gap_i <= gap_prob_i);
      cell_o      = (phase_i == PH_ACTIVE) && (draw_rate_i <= rate_i);
      eop_o       = cell_o && (draw_len_i <= len_prob_i);
      phase_nxt_o = phase_i;
      if (phase_i == PH_ACTIVE) begin
         if (eop_o) phase_nxt_o = gap_done ? PH_ACTIVE : PH_SILENT;
      end else if (gap_done) begin
         phase_nxt_o = PH_ACTIVE;
      end
   end
endmodule

// File: rtl/onoff_tagger.sv
module onoff_tagger #(
   parameter int SEQ_W = 16,
   parameter int PKT_W = 16,
   parameter int VC_W  = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             cell_i,
   input  logic             eop_i,
   input  logic [VC_W-1:0]  vc_i,
   output logic             vld_o,
   output logic             eop_o,
   output logic [SEQ_W-1:0] seq_o,
   output logic [PKT_W-1:0] pkt_o,
   output logic [VC_W-1:0]  vc_o
);
   logic [SEQ_W-1:0] seq_q;
   logic [PKT_W-1:0] pkt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         seq_q <= '0;
         pkt_q <= '0;
         vld_o <= 1'b0;
         eop_o <= 1'b0;
         seq_o <= '0;
         pkt_o <= '0;
         vc_o  <= '0;
      end else begin
         vld_o <= cell_i;
         eop_o <= eop_i;
         if (cell_i) begin
            seq_o <= seq_q;
            pkt_o <= pkt_q;
            vc_o  <= vc_i;
            seq_q <= seq_q + 1'b1;
            if (eop_i) pkt_q <= pkt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/onoff_cell_src.sv
module onoff_cell_src
   import onoff_src_pkg::*;
#(
   parameter int                 LFSR_W   = 16,
   parameter int                 PROB_W   = 8,
   parameter int                 SEQ_W    = 16,
   parameter int                 PKT_W    = 16,
   parameter int                 VC_W     = 12,
   parameter logic [LFSR_W-1:0]  TAPS     = 16'hB400,
   parameter logic [LFSR_W-1:0]  DEF_SEED = 16'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seed_load,
   input  logic [LFSR_W-1:0] seed_val,
   input  logic [PROB_W-1:0] len_prob,
   input  logic [PROB_W-1:0] gap_prob,
   input  logic [PROB_W-1:0] rate,
   input  logic [VC_W-1:0]   vc_label,
   output logic              cell_vld,
   output logic              cell_eop,
   output logic [SEQ_W-1:0]  cell_seq,
   output logic [PKT_W-1:0]  cell_pkt,
   output logic [VC_W-1:0]   cell_vc
);
   if (PROB_W < 1 || PROB_W > LFSR_W) begin : g_bad_prob
      $error("onoff_cell_src: PROB_W must be in 1..LFSR_W");
   end
   if (SEQ_W < 1 || PKT_W < 1 || VC_W < 1) begin : g_bad_tag
      $error("onoff_cell_src: tag widths must be positive");
   end

   logic [PROB_W-1:0] lane_draw [N_LANE];
   logic [N_LANE-1:0] lane_step;
   logic              slot_cell, slot_eop;
   phase_t            phase_q, phase_nxt;

   assign lane_step[LANE_RATE] = 1'b1;
   assign lane_step[LANE_LEN]  = slot_cell;
   assign lane_step[LANE_GAP]  = 1'b1;

   for (genvar g = 0; g < N_LANE; g++) begin : g_lane
      onoff_lfsr #(
         .W       (LFSR_W),
         .DRAW_W  (PROB_W),
         .TAPS    (TAPS),
         .DEF_SEED(DEF_SEED),
         .SALT    (lane_salt(g))
      ) u_lfsr (
         .clk    (clk),
         .rst_n  (rst_n),
         .load_i (seed_load),
         .seed_i (seed_val),
         .step_i (lane_step[g]),
         .draw_o (lane_draw[g])
      );
   end

   onoff_slot_ctrl #(.PROB_W(PROB_W)) u_ctrl (
      .phase_i     (phase_q),
      .draw_rate_i (lane_draw[LANE_RATE]),
      .draw_len_i  (lane_draw[LANE_LEN]),
      .draw_gap_i  (lane_draw[LANE_GAP]),
      .rate_i      (rate),
      .len_prob_i  (len_prob),
      .gap_prob_i  (gap_prob),
      .cell_o      (slot_cell),
      .eop_o       (slot_eop),
      .phase_nxt_o (phase_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || seed_load) phase_q <= PH_ACTIVE;
      else                     phase_q <= phase_nxt;
   end

   onoff_tagger #(.SEQ_W(SEQ_W), .PKT_W(PKT_W), .VC_W(VC_W)) u_tag (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (seed_load),
      .cell_i (slot_cell),
      .eop_i  (slot_eop),
      .vc_i   (vc_label),
      .vld_o  (cell_vld),
      .eop_o  (cell_eop),
      .seq_o  (cell_seq),
      .pkt_o  (cell_pkt),
      .vc_o   (cell_vc)
   );
endmodule

// File: rtl/onoff_cell_src_chk.sv
module onoff_cell_src_chk #(
   parameter int PROB_W = 8,
   parameter int SEQ_W  = 16,
   parameter int PKT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              seed_load,
   input logic [PROB_W-1:0] rate,
   input logic [PROB_W-1:0] len_prob,
   input logic              cell_vld,
   input logic              cell_eop,
   input logic [SEQ_W-1:0]  cell_seq,
   input logic [PKT_W-1:0]  cell_pkt
);
   logic             seen_q, in_pkt_q, in_now;
   logic [SEQ_W-1:0] last_seq_q;
   logic [PKT_W-1:0] last_pkt_q;

   assign in_now = cell_vld ? !cell_eop : in_pkt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || seed_load) begin
         seen_q     <= 1'b0;
         in_pkt_q   <= 1'b0;
         last_seq_q <= '0;
         last_pkt_q <= '0;
      end else if (cell_vld) begin
         seen_q     <= 1'b1;
         in_pkt_q   <= !cell_eop;
         last_seq_q <= cell_seq;
         last_pkt_q <= cell_pkt;
      end
   end

   p_eop_with_vld_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cell_eop |-> cell_vld);

   p_pkt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_vld && seen_q && in_pkt_q) |-> (cell_pkt == last_pkt_q));

   p_pkt_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_vld && seen_q && !in_pkt_q) |-> (cell_pkt == last_pkt_q + 1'b1));

   p_single_cell_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_vld && $past(len_prob) == '1 && !$past(seed_load)) |-> cell_eop);

   p_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_now && rate == '1 && !seed_load) |=> cell_vld);

   p_seq_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_vld && !seen_q) |-> (cell_seq == '0 && cell_pkt == '0));

   p_seq_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_vld && seen_q) |-> (cell_seq == last_seq_q + 1'b1));
endmodule

bind onoff_cell_src onoff_cell_src_chk #(
   .PROB_W(PROB_W), .SEQ_W(SEQ_W), .PKT_W(PKT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .seed_load (seed_load),
   .rate      (rate),
   .len_prob  (len_prob),
   .cell_vld  (cell_vld),
   .cell_eop  (cell_eop),
   .cell_seq  (cell_seq),
   .cell_pkt  (cell_pkt)
);

// File: tb/sim_onoff_cell_src.sv
module sim_onoff_cell_src;
   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seed_load = 1'b0;
   logic [15:0] seed_val = 16'h0;
   logic [7:0]  len_prob = 8'd40;
   logic [7:0]  gap_prob = 8'd60;
   logic [7:0]  rate = 8'hFF;
   logic [11:0] vc_label = 12'h123;
   logic        cell_vld, cell_eop;
   logic [15:0] cell_seq, cell_pkt;
   logic [11:0] cell_vc;

   always #(CLK_NS/2) clk = ~clk;

   onoff_cell_src u0 (
      .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
      .len_prob(len_prob), .gap_prob(gap_prob), .rate(rate), .vc_label(vc_label),
      .cell_vld(cell_vld), .cell_eop(cell_eop), .cell_seq(cell_seq),
      .cell_pkt(cell_pkt), .cell_vc(cell_vc));

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   // ---------------- behavioural reference (from R2..R9) ----------------
   logic [15:0] m_lane [3];
   bit          m_on;
   int          m_seq, m_pkt;
   bit          e_vld, e_eop;
   logic [15:0] e_seq, e_pkt;
   logic [11:0] e_vc;

   function automatic logic [15:0] salt_of(input int k);
      return (k == 1) ? 16'h5A5A : (k == 2) ? 16'hC3C3 : 16'h0000;
   endfunction
   function automatic logic [15:0] seeded(input logic [15:0] s, input int k);
      logic [15:0] v = s ^ salt_of(k);
      return (v == 16'h0) ? 16'h0001 : v;
   endfunction
   function automatic logic [15:0] adv(input logic [15:0] s);
      return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
   endfunction

   task automatic model_clear(input logic [15:0] s);
      for (int k = 0; k < 3; k++) m_lane[k] = seeded(s, k);
      m_on = 1; m_seq = 0; m_pkt = 0;
      e_vld = 0; e_eop = 0; e_seq = 0; e_pkt = 0; e_vc = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_clear(16'hACE1);
      else if (seed_load) model_clear(seed_val);
      else begin
         bit c, eo, gd;
         c  = m_on && (m_lane[0][7:0] <= rate);
         eo = c && (m_lane[1][7:0] <= len_prob);
         gd = (m_lane[2][7:0] <= gap_prob);
         if (m_on) m_on = eo ? gd : 1'b1;
         else      m_on = gd;
         e_vld = c; e_eop = eo;
         if (c) begin
            e_seq = m_seq[15:0]; e_pkt = m_pkt[15:0]; e_vc = vc_label;
            m_seq++;
            if (eo) m_pkt++;
         end
         m_lane[0] = adv(m_lane[0]);
         m_lane[2] = adv(m_lane[2]);
         if (c) m_lane[1] = adv(m_lane[1]);
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
      end
   endtask

   // slot-by-slot comparison, away from the active edge
   bit cmp_en = 0;
   always @(negedge clk) begin
      if (cmp_en && rst_n && !finished) begin
         chk(cell_vld == e_vld, "R4 cell_vld vs model", cell_vld, e_vld);
         chk(cell_eop == e_eop, "R3 cell_eop vs model", cell_eop, e_eop);
         chk(cell_seq == e_seq, "R6 cell_seq vs model", cell_seq, e_seq);
         chk(cell_pkt == e_pkt, "R1 cell_pkt vs model", cell_pkt, e_pkt);
         chk(cell_vc  == e_vc,  "R9 cell_vc vs model",  cell_vc,  e_vc);
      end
   end

   // observation counters
   bit in_pk = 0;
   int inner_gaps = 0, cells = 0, eops = 0, idle_after_eop = 0, busy = 0;
   bit after_eop = 0;
   bit cap_en = 0;
   int cap_cur = 0, cap_n = 0;
   int cap_len [8];
   always @(negedge clk) begin
      if (rst_n) begin
         if (cell_vld) begin
            cells++; busy++;
            if (cell_eop) eops++;
            in_pk = !cell_eop;
            after_eop = cell_eop;
            if (cap_en) begin
               cap_cur++;
               if (cell_eop) begin
                  if (cap_n < 8) cap_len[cap_n] = cap_cur;
                  cap_n++; cap_cur = 0;
               end
            end
         end else begin
            if (in_pk) inner_gaps++;
            if (after_eop) idle_after_eop++;
            after_eop = 0;
         end
      end
   end

   task automatic clear_obs();
      inner_gaps = 0; cells = 0; eops = 0; idle_after_eop = 0; busy = 0;
   endtask

   task automatic do_load(input logic [15:0] s);
      @(negedge clk);
      seed_val = s; seed_load = 1'b1;
      @(negedge clk);
      seed_load = 1'b0;
      in_pk = 0; after_eop = 0;
      chk(cell_vld == 1'b0 && cell_seq == 16'h0 && cell_pkt == 16'h0,
          "R7 idle and cleared after load", {cell_vld, cell_seq, cell_pkt}, 0);
   endtask

   int len_fast [8];

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(cell_vld == 0 && cell_eop == 0 && cell_seq == 0 && cell_pkt == 0 && cell_vc == 0,
          "R8 reset outputs zero", {cell_vld, cell_eop, cell_seq, cell_pkt, cell_vc}, 0);
      rst_n = 1'b1;
      cmp_en = 1;

      // R4: full rate -> back-to-back cells inside packets
      clear_obs();
      repeat (300) @(negedge clk);
      chk(inner_gaps == 0, "R4 no idle slot inside packet at rate 255", inner_gaps, 0);
      chk(cells > 0, "R4 cells emitted at rate 255", cells, 1);

      // R4: reduced rate spaces cells
      rate = 8'd50;
      repeat (5) @(negedge clk);
      clear_obs();
      repeat (400) @(negedge clk);
      chk(inner_gaps > 0, "R4 idle slots inside packets at rate 50", inner_gaps, 1);

      // R3: len_prob 255 -> single-cell packets
      rate = 8'hFF; len_prob = 8'hFF;
      repeat (2) @(negedge clk);
      clear_obs();
      repeat (200) @(negedge clk);
      chk(cells == eops && cells > 0, "R3 every cell ends its packet", eops, cells);

      // R2: gap_prob 255 -> zero-length silence, end-of-packet and end-of-gap together
      len_prob = 8'd30; gap_prob = 8'hFF;
      repeat (3) @(negedge clk);
      clear_obs();
      repeat (100) @(negedge clk);
      chk(busy == 100, "R2 no idle slot with gap_prob 255", busy, 100);
      chk(eops > 0, "R2 packets closed back to back", eops, 1);

      // R2: gap_prob 0 -> long silence after each packet
      len_prob = 8'hFF; gap_prob = 8'd0;
      repeat (2) @(negedge clk);
      clear_obs();
      repeat (1500) @(negedge clk);
      chk(idle_after_eop > 0, "R2 idle slots follow end of packet", idle_after_eop, 1);
      chk(busy < 300, "R2 silence dominates at gap_prob 0", busy, 300);

      // R5 / R7: same seed, different rate -> identical packet lengths
      len_prob = 8'd50; gap_prob = 8'd80; rate = 8'hFF;
      do_load(16'h1F2E);
      cap_en = 1; cap_n = 0; cap_cur = 0;
      for (int t = 0; t < 3000 && cap_n < 8; t++) @(negedge clk);
      cap_en = 0;
      for (int k = 0; k < 8; k++) len_fast[k] = cap_len[k];
      chk(cap_n >= 8, "R5 eight packets captured at rate 255", cap_n, 8);

      rate = 8'd40;
      do_load(16'h1F2E);
      cap_en = 1; cap_n = 0; cap_cur = 0;
      for (int t = 0; t < 6000 && cap_n < 8; t++) @(negedge clk);
      cap_en = 0;
      chk(cap_n >= 8, "R5 eight packets captured at rate 40", cap_n, 8);
      for (int k = 0; k < 8; k++)
         chk(cap_len[k] == len_fast[k], "R5 packet length independent of rate",
             cap_len[k], len_fast[k]);

      // R9: label follows input
      rate = 8'hFF; gap_prob = 8'hFF;
      vc_label = 12'hABC;
      @(negedge clk); @(negedge clk);
      chk(cell_vld && cell_vc == 12'hABC, "R9 label stamped on cell", cell_vc, 12'hABC);

      // R6 / R7: load in mid-packet, first cell restarts numbering
      len_prob = 8'd10;
      repeat (7) @(negedge clk);
      do_load(16'h0000);
      @(negedge clk);
      chk(cell_vld && cell_seq == 0 && cell_pkt == 0, "R6 first cell after load numbered zero",
          {cell_seq, cell_pkt}, 0);
      repeat (50) @(negedge clk);

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(CLK_NS * 150000);
      if (!finished) begin
         finished = 1;
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule